// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block produces the timing skeleton of a raster display: horizontal sync, vertical sync, a composite sync and a blanking signal. It also produces a one-cycle strobe at the last pixel clock of each line and another at the last pixel clock of each frame. It runs on the pixel clock. A horizontal counter steps once per clock. A vertical counter steps once per completed line.

Each axis is programmed at run time from two 32-bit words:

- A timing word with three fields:
  - sync width in bits [31:24];
  - back-porch delay in bits [23:16];
  - visible gate length in bits [15:0].
- A shared period word, which holds the horizontal total in bits [31:16] and the vertical total in bits [15:0].

Every programmed value is one less than the count it stands for. Each of the four sync and blank outputs has its own polarity input. A pixel pipeline downstream uses the deasserted blank as its data-valid qualifier.

Top module: `vid_sync_gen`

## Requirements
- R1: While rst_ni is low, every output is 0.
- R2: The horizontal counter runs from 0 to the horizontal total T and then returns to 0, so a line is T+1 clocks long. hsync is active while the count is at most the sync field S. With delay field D and gate field G, the horizontal visible window covers counts S+D+2 through S+D+G+2.
- R3: The vertical counter advances once per completed line and wraps after its own total. vsync and the vertical visible window decode its count with the same rules as R2, using the vertical fields.
- R4: blank is active whenever the horizontal count or the vertical count lies outside its visible window.
- R5: csync is active when hsync or vsync is active; this is evaluated on the active-high levels, before polarity.
- R6: line_end_o pulses high for exactly one clock, on the clock that shows the last horizontal count of each line.
- R7: frame_end_o pulses high only together with line_end_o, on the last line of the frame.
- R8: Each of hpol_i, vpol_i, cpol_i and bpol_i, when set to 1, inverts its own output: hsync, vsync, csync and blank respectively.
- R9: While en_i is low, both counters are held at 0. hsync, vsync, csync and blank sit at their inactive level (equal to the polarity input), and both strobes are low.
- R10: Outputs are registered one clock behind the counters. After en_i rises, the first output clock shows count 0 on both axes.
- R11: If a total is lowered below the current count, that axis wraps to 0 on the next step instead of running on to the counter limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | pixel clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| en_i | input | 1 | run enable |
| htim_i | input | 32 | horizontal sync[31:24], delay[23:16], gate[15:0] |
| vtim_i | input | 32 | vertical sync[31:24], delay[23:16], gate[15:0] |
| len_i | input | 32 | horizontal total[31:16], vertical total[15:0] |
| hpol_i | input | 1 | invert hsync |
| vpol_i | input | 1 | invert vsync |
| cpol_i | input | 1 | invert csync |
| bpol_i | input | 1 | invert blank |
| hsync_o | output | 1 | horizontal sync |
| vsync_o | output | 1 | vertical sync |
| csync_o | output | 1 | composite sync |
| blank_o | output | 1 | blanking |
| line_end_o | output | 1 | last clock of a line |
| frame_end_o | output | 1 | last clock of a frame |

## Verification
Some rules can be judged from a single clock edge, and the checker holds them on every cycle:

- csync always matches the OR of the de-polarised syncs;
- a frame strobe never appears without a line strobe;
- the vertical count moves only at a line wrap or when disabled;
- the idle state is enforced while disabled.

The exact phase positions need a reference count of elapsed clocks, and only the bench scenarios can show them. The same applies to the line and frame lengths, the blank window, the restart from zero and the early wrap after a total is lowered. The bench compares every output on every clock of whole frames in several modes.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned FLD_W  = 8;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic [FLD_W-1:0] sync_len;
    logic [FLD_W-1:0] dly_len;
    logic [CNT_W-1:0] gate_len;
  } axis_tim_t;

  typedef struct packed {
    logic [CNT_W-1:0] h_total;
    logic [CNT_W-1:0] v_total;
  } period_t;
endpackage

// File: rtl/vsg_axis.sv
module vsg_axis #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned FLD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic [FLD_W-1:0] sync_i,
  input  logic [FLD_W-1:0] dly_i,
  input  logic [CNT_W-1:0] gate_i,
  input  logic [CNT_W-1:0] total_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             sync_o,
  output logic             vis_o
);
  localparam int unsigned EXT_W = CNT_W + 2;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_x, vis_lo, vis_hi;

  // >= so a lowered total wraps at once
  assign wrap_o = step_i && (cnt_q >= total_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!en_i)     cnt_q <= '0;
    else if (wrap_o)    cnt_q <= '0;
    else if (step_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_x  = EXT_W'(cnt_q);
  assign vis_lo = EXT_W'(sync_i) + EXT_W'(dly_i) + EXT_W'(2);
  assign vis_hi = vis_lo + EXT_W'(gate_i);

  assign sync_o = cnt_x <= EXT_W'(sync_i);
  assign vis_o  = (cnt_x >= vis_lo) && (cnt_x <= vis_hi);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/vsg_out_stage.sv
module vsg_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hs_i,
  input  logic vs_i,
  input  logic hvis_i,
  input  logic vvis_i,
  input  logic line_i,
  input  logic frame_i,
  input  logic hpol_i,
  input  logic vpol_i,
  input  logic cpol_i,
  input  logic bpol_i,
  output logic hsync_o,
  output logic vsync_o,
  output logic csync_o,
  output logic blank_o,
  output logic line_end_o,
  output logic frame_end_o
);
  logic hs_a, vs_a, cs_a, bl_a;

  assign hs_a = en_i & hs_i;
  assign vs_a = en_i & vs_i;
  assign cs_a = hs_a | vs_a;
  assign bl_a = en_i & ~(hvis_i & vvis_i);

  // polarity folded in ahead of the flops: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o     <= 1'b0;
      vsync_o     <= 1'b0;
      csync_o     <= 1'b0;
      blank_o     <= 1'b0;
      line_end_o  <= 1'b0;
      frame_end_o <= 1'b0;
    end else begin
      hsync_o     <= hs_a ^ hpol_i;
      vsync_o     <= vs_a ^ vpol_i;
      csync_o     <= cs_a ^ cpol_i;
      blank_o     <= bl_a ^ bpol_i;
      line_end_o  <= en_i & line_i;
      frame_end_o <= en_i & frame_i;
    end
  end
endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen
  import vsg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WORD_W-1:0] htim_i,
  input  logic [WORD_W-1:0] vtim_i,
  input  logic [WORD_W-1:0] len_i,
  input  logic              hpol_i,
  input  logic              vpol_i,
  input  logic              cpol_i,
  input  logic              bpol_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              csync_o,
  output logic              blank_o,
  output logic              line_end_o,
  output logic              frame_end_o
);
  axis_tim_t        h_tim, v_tim;
  period_t          per;
  logic [CNT_W-1:0] h_cnt, v_cnt;
  logic             h_wrap, v_wrap, h_sync, v_sync, h_vis, v_vis;

  assign h_tim = axis_tim_t'(htim_i);
  assign v_tim = axis_tim_t'(vtim_i);
  assign per   = period_t'(len_i);

  vsg_axis #(.CNT_W(CNT_W), .FLD_W(FLD_W)) u_h_axis (
    .clk_i, .rst_ni, .en_i,
    .step_i (1'b1),
    .sync_i (h_tim.sync_len),
    .dly_i  (h_tim.dly_len),
    .gate_i (h_tim.gate_len),
    .total_i(per.h_total),
    .cnt_o  (h_cnt),
    .wrap_o (h_wrap),
    .sync_o (h_sync),
    .vis_o  (h_vis)
  );

  vsg_axis #(.CNT_W(CNT_W), .FLD_W(FLD_W)) u_v_axis (
    .clk_i, .rst_ni, .en_i,
    .step_i (h_wrap),
    .sync_i (v_tim.sync_len),
    .dly_i  (v_tim.dly_len),
    .gate_i (v_tim.gate_len),
    .total_i(per.v_total),
    .cnt_o  (v_cnt),
    .wrap_o (v_wrap),
    .sync_o (v_sync),
    .vis_o  (v_vis)
  );

  vsg_out_stage u_out (
    .clk_i, .rst_ni, .en_i,
    .hs_i   (h_sync),
    .vs_i   (v_sync),
    .hvis_i (h_vis),
    .vvis_i (v_vis),
    .line_i (h_wrap),
    .frame_i(v_wrap),
    .hpol_i, .vpol_i, .cpol_i, .bpol_i,
    .hsync_o, .vsync_o, .csync_o, .blank_o, .line_end_o, .frame_end_o
  );
endmodule

// File: rtl/vid_sync_gen_chk.sv
module vid_sync_gen_chk
  import vsg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [WORD_W-1:0] len_i,
  input logic              hpol_i,
  input logic              vpol_i,
  input logic              cpol_i,
  input logic              bpol_i,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              csync_o,
  input logic              blank_o,
  input logic              line_end_o,
  input logic              frame_end_o,
  input logic [CNT_W-1:0]  h_cnt,
  input logic [CNT_W-1:0]  v_cnt
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;

  a_r5_csync_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> ((csync_o ^ $past(cpol_i)) ==
               ((hsync_o ^ $past(hpol_i)) | (vsync_o ^ $past(vpol_i)))));

  a_r7_frame_with_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> line_end_o);

  a_r9_idle_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (hsync_o == $past(hpol_i)) && (vsync_o == $past(vpol_i)) &&
              (csync_o == $past(cpol_i)) && (blank_o == $past(bpol_i)) &&
              !line_end_o && !frame_end_o);

  a_r9_idle_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (h_cnt == '0) && (v_cnt == '0));

  a_r3_v_steps_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(v_cnt) |-> (!$past(en_i) || ($past(h_cnt) >= $past(len_i[31:16]))));
endmodule

bind vid_sync_gen vid_sync_gen_chk u_chk (
  .clk_i, .rst_ni, .en_i, .len_i,
  .hpol_i, .vpol_i, .cpol_i, .bpol_i,
  .hsync_o, .vsync_o, .csync_o, .blank_o, .line_end_o, .frame_end_o,
  .h_cnt, .v_cnt
);

// File: tb/vid_sync_gen_tb.sv
module vid_sync_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [31:0] htim_i = '0, vtim_i = '0, len_i = '0;
  logic        hpol_i = 1'b0, vpol_i = 1'b0, cpol_i = 1'b0, bpol_i = 1'b0;
  logic        hsync_o, vsync_o, csync_o, blank_o, line_end_o, frame_end_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  vid_sync_gen u_dut (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic setup(int hs, int hd, int hg, int ht, int vs, int vd, int vg, int vt,
                       logic [3:0] pol);
    @(negedge clk_i);
    en_i = 1'b0;
    htim_i = {8'(hs), 8'(hd), 16'(hg)};
    vtim_i = {8'(vs), 8'(vd), 16'(vg)};
    len_i  = {16'(ht), 16'(vt)};
    {hpol_i, vpol_i, cpol_i, bpol_i} = pol;
    repeat (2) @(negedge clk_i);
  endtask

  // Enable, then compare every output against a count of elapsed clocks
  task automatic run_mode(int hs, int hd, int hg, int ht, int vs, int vd, int vg, int vt,
                          logic [3:0] pol, int frames);
    int ncyc = (ht + 1) * (vt + 1) * frames;
    setup(hs, hd, hg, ht, vs, vd, vg, vt, pol);
    en_i = 1'b1;
    for (int e = 0; e < ncyc; e++) begin
      int h = e % (ht + 1);
      int v = (e / (ht + 1)) % (vt + 1);
      logic ehs = h <= hs;
      logic evs = v <= vs;
      logic ehv = (h >= hs + hd + 2) && (h <= hs + hd + hg + 2);
      logic evv = (v >= vs + vd + 2) && (v <= vs + vd + vg + 2);
      @(negedge clk_i);
      chk("R2 hsync", hsync_o, ehs ^ pol[3]);
      chk("R3 vsync", vsync_o, evs ^ pol[2]);
      chk("R5 csync", csync_o, (ehs | evs) ^ pol[1]);
      chk("R4 blank", blank_o, !(ehv && evv) ^ pol[0]);
      chk("R6 line_end", line_end_o, h == ht);
      chk("R7 frame_end", frame_end_o, (h == ht) && (v == vt));
      if (pol != 4'b0000 && e == 0) chk("R8 pol_hsync", hsync_o, 1'b1 ^ pol[3]);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset outs", {hsync_o, vsync_o, csync_o, blank_o, line_end_o, frame_end_o}, 0);
  endtask

  task automatic t_idle();
    setup(1, 1, 3, 9, 0, 0, 2, 5, 4'b1111);
    repeat (5) begin
      @(negedge clk_i);
      chk("R9 idle inverted", {hsync_o, vsync_o, csync_o, blank_o, line_end_o, frame_end_o},
          6'b111100);
    end
    setup(1, 1, 3, 9, 0, 0, 2, 5, 4'b0000);
    chk("R9 idle plain", {hsync_o, vsync_o, csync_o, blank_o, line_end_o, frame_end_o}, 0);
  endtask

  // Stop mid-frame: expect idle; restarting must begin at count 0 (R10)
  task automatic t_restart();
    setup(1, 0, 3, 7, 0, 0, 1, 4, 4'b0000);
    en_i = 1'b1;
    repeat (19) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R9 stop idle", {hsync_o, vsync_o, csync_o, blank_o, line_end_o}, 0);
    en_i = 1'b1;
    @(negedge clk_i);
    chk("R10 restart hsync", hsync_o, 1'b1);
    chk("R10 restart vsync", vsync_o, 1'b1);
    for (int k = 1; k < 8; k++) begin
      @(negedge clk_i);
      chk("R10 restart line_end", line_end_o, k == 7);
    end
  endtask

  // Lower the horizontal total below the running count (R11)
  task automatic t_shrink();
    int wait_c = 0, gap = 0;
    setup(2, 2, 100, 200, 0, 0, 3, 6, 4'b0000);
    en_i = 1'b1;
    repeat (150) @(negedge clk_i);
    len_i = {16'd20, 16'd6};
    @(negedge clk_i);
    while (!line_end_o && wait_c < 300) begin
      wait_c++;
      @(negedge clk_i);
    end
    chk("R11 early wrap delay", wait_c, 0);
    @(negedge clk_i);
    while (!line_end_o && gap < 300) begin
      gap++;
      @(negedge clk_i);
    end
    chk("R11 new line length", gap + 1, 21);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_idle();
    run_mode(1, 2, 3, 11, 0, 1, 2, 6, 4'b0000, 2);
    run_mode(1, 2, 3, 11, 0, 1, 2, 6, 4'b1010, 1);
    run_mode(1, 2, 3, 11, 0, 1, 2, 6, 4'b0101, 1);
    run_mode(0, 0, 0, 4, 0, 0, 0, 3, 4'b0000, 2);
    t_restart();
    t_shrink();
    run_mode(0, 0, 340, 345, 0, 0, 240, 245, 4'b0000, 1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk_i);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog got=timeout exp=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule